// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block connects a synchronous request/acknowledge bus inside a chip to an external asynchronous static RAM that stores 131072 words of 16 bits. Every word has two byte lanes, and each lane has its own active-low enable on the memory side. The requester supplies a 17-bit word address, write data, a read/write flag and one active-high mask bit per lane. The controller then generates the memory's active-low chip select, write strobe, output enable and lane enables. It also drives the address and controls the direction of the data bus.

Every strobe is held low for `ACCESS_CYC` clock cycles. This parameter is the memory access time (45 ns) divided by the clock period and rounded up. A write is framed by one setup cycle before the write strobe falls and one hold cycle after it rises. During these cycles the address, lane enables and write data do not change. A read returns the word with a one-cycle valid strobe, and every lane the requester did not select is forced to zero. The data driver is enabled only while the output enable has been high for the current cycle and the one before it. This keeps the controller and the memory from driving the bus together.

A request whose lane mask is all zero never touches the memory pins. It completes in the next cycle. Requests are taken only while the controller is idle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While idle (`req_ready` high), the controller holds `sram_ce_n`, `sram_we_n`, `sram_oe_n` and every `sram_be_n` bit high, and keeps `sram_dq_oe` low. Reset puts the controller in the idle state with `wr_ack` and `rd_valid` low.
- R2: A write keeps `sram_ce_n` low and pulls `sram_we_n` low for exactly `ACCESS_CYC` cycles. The address, lane enables and write data are already stable, and the bus is already driven, one cycle before `sram_we_n` falls. They stay unchanged, with the bus driven and `sram_ce_n` low, in the cycle in which `sram_we_n` rises.
- R3: Lane mask bit 0 selects data bits 7:0 and drives `sram_be_n[0]` low. Bit 1 selects bits 15:8 and drives `sram_be_n[1]` low. A write changes only the selected lanes of the stored word.
- R4: A read holds `sram_ce_n` and `sram_oe_n` low for exactly `ACCESS_CYC` cycles. During that time `sram_we_n` is high and `sram_dq_oe` is low.
- R5: `rd_valid` is a one-cycle pulse in the cycle after the last read cycle. `rd_data` then holds the sampled word, with every unselected lane set to zero. A read with a nonzero mask completes `ACCESS_CYC`+1 cycles after it is accepted.
- R6: `sram_oe_n` stays high throughout a write. `sram_dq_oe` is high only when `sram_oe_n` is high in both the current cycle and the previous one.
- R7: A request is accepted only while `req_ready` is high. A request presented while the controller is busy is ignored: the address and data sent to the memory do not change, and no second access follows.
- R8: `wr_ack` is a one-cycle pulse in the cycle after the hold cycle. A write with a nonzero mask completes `ACCESS_CYC`+3 cycles after it is accepted. `wr_ack` and `rd_valid` are never high together.
- R9: A request whose mask is all zero completes in the next cycle, with `wr_ack` for a write or with `rd_valid` and a zero `rd_data` for a read. `sram_ce_n` stays high and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Active-high lane mask (bit 0 = bits 7:0) |
| req_ready | output | 1 | Controller idle, request can be taken |
| wr_ack | output | 1 | Write done, one cycle |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 16 | Read word, unselected lanes zero |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_be_n | output | 2 | Memory lane enables, active low |
| sram_addr | output | 17 | Memory word address |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
The assertions check the following on every cycle: the strobe pulse lengths, setup and hold around the write strobe, bus-contention avoidance, idle deselection, that busy-time requests are ignored, and that completion pulses last one cycle. The bench drives an attached memory model. Only through that model can it show what the assertions cannot: that partial writes keep the untouched lane, that unselected read lanes come back as zero, that the completion latencies are right, and that a zero-mask request neither stores nor strobes.

// File: rtl/sbc_pkg.sv
`timescale 1ns/1ps
package sbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WSETUP = 3'd1,
      ST_WPULSE = 3'd2,
      ST_WHOLD  = 3'd3,
      ST_RACC   = 3'd4
   } sbc_state_t;
endpackage

// File: rtl/sbc_wait_timer.sv
`timescale 1ns/1ps
module sbc_wait_timer #(
   parameter int CYCLES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic last
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/sbc_lane_mask.sv
`timescale 1ns/1ps
module sbc_lane_mask #(
   parameter int LANES = 2,
   parameter int LANE_W = 8
) (
   input  logic [LANES*LANE_W-1:0] din,
   input  logic [LANES-1:0]        en,
   output logic [LANES*LANE_W-1:0] dout
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign dout[l*LANE_W +: LANE_W] = en[l] ? din[l*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/sbc_pin_decode.sv
`timescale 1ns/1ps
module sbc_pin_decode
   import sbc_pkg::*;
#(
   parameter int LANES = 2
) (
   input  sbc_state_t       state,
   input  logic [LANES-1:0] lane_sel,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic [LANES-1:0] be_n,
   output logic             dq_oe
);
   logic busy, wr_phase;

   always_comb begin
      busy     = (state != ST_IDLE);
      wr_phase = (state == ST_WSETUP) || (state == ST_WPULSE) || (state == ST_WHOLD);
      ce_n     = !busy;
      we_n     = (state != ST_WPULSE);
      oe_n     = (state != ST_RACC);
      dq_oe    = wr_phase;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_be
      assign be_n[l] = !(busy && lane_sel[l]);
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
   import sbc_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int ACCESS_CYC = 3,
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              req_ready,
   output logic              wr_ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [LANES-1:0]  sram_be_n,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dq_out,
   output logic              sram_dq_oe,
   input  logic [DATA_W-1:0] sram_dq_in
);
   localparam int RW = $clog2(ACCESS_CYC + 2);
   localparam logic [RW-1:0] PULSE_LEN = RW'(ACCESS_CYC);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (ACCESS_CYC < 1) begin : g_bad_cyc
      $error("ACCESS_CYC must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   sbc_state_t        state, state_nx;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [LANES-1:0]  sel_q;
   logic              accept, empty_mask, tmr_start, tmr_last;
   logic [DATA_W-1:0] masked_rd;

   assign req_ready  = (state == ST_IDLE);
   assign accept     = req_ready && req_valid;
   assign empty_mask = (req_be == '0);
   assign tmr_start  = (accept && !empty_mask && !req_write) || (state == ST_WSETUP);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:   if (accept && !empty_mask) state_nx = req_write ? ST_WSETUP : ST_RACC;
         ST_WSETUP: state_nx = ST_WPULSE;
         ST_WPULSE: if (tmr_last) state_nx = ST_WHOLD;
         ST_WHOLD:  state_nx = ST_IDLE;
         ST_RACC:   if (tmr_last) state_nx = ST_IDLE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         addr_q   <= '0;
         data_q   <= '0;
         sel_q    <= '0;
         wr_ack   <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         state    <= state_nx;
         wr_ack   <= 1'b0;
         rd_valid <= 1'b0;
         if (accept && !empty_mask) begin
            addr_q <= req_addr;
            data_q <= req_wdata;
            sel_q  <= req_be;
         end
         if (accept && empty_mask) begin
            wr_ack   <= req_write;
            rd_valid <= !req_write;
            rd_data  <= '0;
         end
         if (state == ST_WHOLD) wr_ack <= 1'b1;
         if (state == ST_RACC && tmr_last) begin
            rd_valid <= 1'b1;
            rd_data  <= masked_rd;
         end
      end
   end

   sbc_wait_timer #(.CYCLES(ACCESS_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .last(tmr_last)
   );

   sbc_lane_mask #(.LANES(LANES), .LANE_W(8)) i_mask (
      .din(sram_dq_in), .en(sel_q), .dout(masked_rd)
   );

   sbc_pin_decode #(.LANES(LANES)) i_pins (
      .state(state), .lane_sel(sel_q),
      .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
      .be_n(sram_be_n), .dq_oe(sram_dq_oe)
   );

   assign sram_addr   = addr_q;
   assign sram_dq_out = data_q;

   // Strobe run-length counters used only by the checks below
   logic [RW-1:0] we_run, oe_run;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_run <= '0;
         oe_run <= '0;
      end else begin
         we_run <= sram_we_n ? '0 : we_run + 1'b1;
         oe_run <= sram_oe_n ? '0 : oe_run + 1'b1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> sram_ce_n && sram_we_n && sram_oe_n && (&sram_be_n) && !sram_dq_oe);

   assert_we_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> we_run == PULSE_LEN);

   assert_wr_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $stable(sram_addr) && $stable(sram_be_n) && $stable(sram_dq_out)
                           && $past(sram_dq_oe) && $past(!sram_ce_n));

   assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> sram_dq_oe && !sram_ce_n && $stable(sram_addr)
                           && $stable(sram_be_n) && $stable(sram_dq_out));

   assert_write_needs_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> !sram_ce_n && sram_oe_n);

   assert_rd_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> sram_we_n && !sram_ce_n && !sram_dq_oe);

   assert_oe_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_oe_n) |-> oe_run == PULSE_LEN);

   for (genvar l = 0; l < LANES; l++) begin : g_rd_chk
      assert_rd_lane_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_valid && $past(sram_be_n[l])) |-> rd_data[l*8 +: 8] == 8'h00);
   end

   assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dq_oe |-> sram_oe_n && $past(sram_oe_n));

   assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(sram_addr) && $stable(sram_dq_out));

   assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack |=> !wr_ack);

   assert_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ack && rd_valid));

   assert_empty_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && req_be == '0) |=> sram_ce_n && (wr_ack || rd_valid));
endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
   localparam int CLK_PERIOD = 15;
   localparam int ACC = (45 + CLK_PERIOD - 1) / CLK_PERIOD;
   localparam int NVEC = 13;

   // Vector layout: [51] write, [50:34] address, [33:18] wdata, [17:16] mask, [15:0] expected read
   localparam logic [51:0] VEC [NVEC] = '{
      {1'b1, 17'h00001, 16'h1234, 2'b11, 16'h0000},
      {1'b0, 17'h00001, 16'h0000, 2'b11, 16'h1234},
      {1'b1, 17'h00001, 16'hABCD, 2'b01, 16'h0000},
      {1'b0, 17'h00001, 16'h0000, 2'b11, 16'h12CD},
      {1'b1, 17'h00001, 16'h5678, 2'b10, 16'h0000},
      {1'b0, 17'h00001, 16'h0000, 2'b11, 16'h56CD},
      {1'b0, 17'h00001, 16'h0000, 2'b01, 16'h00CD},
      {1'b0, 17'h00001, 16'h0000, 2'b10, 16'h5600},
      {1'b1, 17'h1FFFE, 16'hFFFF, 2'b11, 16'h0000},
      {1'b0, 17'h1FFFE, 16'h0000, 2'b11, 16'hFFFF},
      {1'b1, 17'h00002, 16'h9999, 2'b00, 16'h0000},
      {1'b0, 17'h00002, 16'h0000, 2'b11, 16'h0000},
      {1'b0, 17'h00002, 16'h0000, 2'b00, 16'h0000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, wr_ack, rd_valid, sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [15:0] rd_data, sram_dq_out, sram_dq_in;
   logic [1:0]  sram_be_n;
   logic [16:0] sram_addr;

   int n_chk = 0, n_fail = 0;
   int we_cnt = 0, oe_cnt = 0, ce_cnt = 0, clash_cnt = 0;
   logic [15:0] mem [16];

   always #(CLK_PERIOD/2.0) clk = ~clk;

   sram_lane_ctrl #(.ACCESS_CYC(ACC)) i_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .req_ready(req_ready), .wr_ack(wr_ack), .rd_valid(rd_valid), .rd_data(rd_data),
      .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_be_n(sram_be_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
      .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   // Memory model keyed by the low four address bits; garbage on lanes not enabled
   assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ?
      {sram_be_n[1] ? 8'hA5 : mem[sram_addr[3:0]][15:8],
       sram_be_n[0] ? 8'h5A : mem[sram_addr[3:0]][7:0]} : 16'h0F0F;

   initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

   always @(posedge clk) begin
      if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
         if (!sram_be_n[0]) mem[sram_addr[3:0]][7:0]  <= sram_dq_out[7:0];
         if (!sram_be_n[1]) mem[sram_addr[3:0]][15:8] <= sram_dq_out[15:8];
      end
      if (!sram_we_n) we_cnt <= we_cnt + 1;
      if (!sram_oe_n) oe_cnt <= oe_cnt + 1;
      if (!sram_ce_n) ce_cnt <= ce_cnt + 1;
      if (sram_dq_oe && !sram_oe_n) clash_cnt <= clash_cnt + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic wr, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] be, input logic [15:0] exp);
      int cyc, w0, o0, c0, lat;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      w0 = we_cnt; o0 = oe_cnt; c0 = ce_cnt;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (!(wr_ack || rd_valid) && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
      if (be == 2'b00) begin
         chk("R9 latency", cyc, 1);
         chk("R9 no chip select", ce_cnt - c0, 0);
         chk(wr ? "R9 ack kind" : "R9 valid kind", wr ? wr_ack : rd_valid, 1);
         if (!wr) chk("R9 zero data", rd_data, 16'h0000);
      end else if (wr) begin
         lat = ACC + 3;
         chk("R8 write latency", cyc, lat);
         chk("R2 we_n low cycles", we_cnt - w0, ACC);
         chk("R2 ce_n low cycles", ce_cnt - c0, ACC + 2);
         chk("R6 oe_n high in write", oe_cnt - o0, 0);
      end else begin
         lat = ACC + 1;
         chk("R5 read latency", cyc, lat);
         chk("R4 oe_n low cycles", oe_cnt - o0, ACC);
         chk("R4 we_n high in read", we_cnt - w0, 0);
         chk("R5 R3 read data", rd_data, exp);
      end
      @(negedge clk);
      chk(wr ? "R8 ack one cycle" : "R5 valid one cycle", wr ? wr_ack : rd_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset ready", req_ready, 1);
      chk("R1 reset pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe}, 6'b111110);
      chk("R1 reset done flags", {wr_ack, rd_valid}, 2'b00);

      for (int v = 0; v < NVEC; v++)
         do_op(VEC[v][51], VEC[v][50:34], VEC[v][33:18], VEC[v][17:16], VEC[v][15:0]);

      // R9: zero-mask write must not have stored anything at address 2
      chk("R9 nothing stored", mem[2], 16'h0000);

      // R7: request while busy is ignored
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00003; req_wdata = 16'h3333; req_be = 2'b11;
      @(negedge clk);
      req_addr = 17'h00004; req_wdata = 16'h4444;
      chk("R7 busy not ready", req_ready, 0);
      @(negedge clk);
      chk("R7 address held", sram_addr, 17'h00003);
      req_valid = 1'b0;
      while (!wr_ack) @(negedge clk);
      repeat (3) begin
         @(negedge clk);
         chk("R7 no second access", sram_ce_n, 1);
      end
      chk("R7 busy data dropped", mem[4], 16'h0000);
      do_op(1'b0, 17'h00003, 16'h0000, 2'b11, 16'h3333);

      // R1: idle pins after activity
      @(negedge clk);
      chk("R1 idle pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, sram_dq_oe}, 6'b111110);
      chk("R6 no bus clash", clash_cnt, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule